// File: doc/BRIEF.md
# Masked Vector Integer ALU

This block is the integer arithmetic stage of a vector unit. It receives two full-width source vectors, an optional scalar operand, the mask register contents, a mask-enable flag, an operation code, the element-width selector and the active vector length. On the next rising clock edge it presents a complete destination vector that the register file can take in a single full-register write.

The vector is split into lanes at run time. The width selector picks 8-, 16- or 32-bit elements, and no carry or borrow crosses a lane boundary. Each element is then treated in one of three ways:

- Elements at or beyond the vector length keep the second source unchanged.
- Elements switched off by the mask keep the second source, except under the move operation, which writes zero into them.
- All other elements receive the result of the operation.

The second operand of each operation comes either from the first source vector or from the scalar, which is truncated to the element width and copied to every element.

Top module: `valu_top`

## Requirements
- R1: While `rst_n` is low, `result` is all zeros, and it stays all zeros until the first rising edge after `rst_n` goes high.
- R2: The inputs present at a rising clock edge determine `result` after that edge, and `result` holds that value until the next edge. All elements are updated together.
- R3: `sew` 0, 1 and 2 select element widths of 8, 16 and 32 bits. Element i occupies bits [i*W +: W]. Add and subtract wrap modulo 2^W and never carry into a neighbouring element.
- R4: The operation codes are 0 = add (vs2 + operand), 1 = subtract (vs2 - operand), 2 = AND, 3 = OR, 4 = XOR and 5 = move (operand). Codes 6 and 7 leave every element equal to vs2.
- R5: Elements with an index equal to or greater than `vl` equal the vs2 element, whatever the operation and the mask.
- R6: With `scalar_sel` = 1, the operand of every element is `scalar[W-1:0]` instead of the vs1 element.
- R7: With `mask_en` = 1, an element is active only when bit i*W of `v0` is 1. An inactive element under operation codes other than move equals the vs2 element.
- R8: With `mask_en` = 1, an inactive element under the move operation is zero.
- R9: With `mask_en` = 0, every element below `vl` is active, whatever the contents of `v0`.
- R10: `sew` = 3 is reserved, and it makes `result` equal to vs2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vs1 | input | VLEN | First source vector |
| vs2 | input | VLEN | Second source vector; also the pass-through value |
| v0 | input | VLEN | Mask register contents |
| scalar | input | XLEN | Scalar operand |
| scalar_sel | input | 1 | 1 selects the scalar as operand |
| mask_en | input | 1 | 1 enables masking by `v0` |
| op | input | 3 | Operation code |
| sew | input | 2 | Element width code |
| vl | input | VL_W | Active vector length in elements |
| result | output | VLEN | Registered destination vector |

## Verification
The hardest case to reach from the ports is the interaction of three things at a lane boundary: the element width, the vector length and the mask bit position. A mask bit at position i*W counts for one width but is ignored at another, and `vl` cuts off a different number of bytes for each width. The stimulus therefore reuses the same `v0` and `vl` across all three widths. It adds directed all-ones carry patterns that would spill into a neighbouring lane, and then a long run of random operands, mask words, lengths and width codes, each compared with a behavioural reference.

// File: rtl/valu_pkg.sv
package valu_pkg;
   typedef enum logic [2:0] {
      OP_ADD = 3'd0,
      OP_SUB = 3'd1,
      OP_AND = 3'd2,
      OP_OR  = 3'd3,
      OP_XOR = 3'd4,
      OP_MV  = 3'd5,
      OP_R6  = 3'd6,
      OP_R7  = 3'd7
   } valu_op_e;

   localparam logic [1:0] SEW_8   = 2'd0;
   localparam logic [1:0] SEW_16  = 2'd1;
   localparam logic [1:0] SEW_32  = 2'd2;
   localparam logic [1:0] SEW_RSV = 2'd3;
   localparam int unsigned N_WIDTHS = 3;
endpackage

// File: rtl/valu_lane.sv
module valu_lane #(
   parameter int unsigned W = 8
) (
   input  logic [W-1:0]     opnd,
   input  logic [W-1:0]     base,
   input  valu_pkg::valu_op_e op,
   input  logic             active,
   input  logic             in_range,
   output logic [W-1:0]     elem
);
   import valu_pkg::*;

   logic [W-1:0] f;

   always_comb begin
      unique case (op)
         OP_ADD:  f = base + opnd;
         OP_SUB:  f = base - opnd;
         OP_AND:  f = base & opnd;
         OP_OR:   f = base | opnd;
         OP_XOR:  f = base ^ opnd;
         OP_MV:   f = opnd;
         default: f = base;
      endcase
   end

   always_comb begin
      if (!in_range)       elem = base;
      else if (!active)    elem = (op == OP_MV) ? '0 : base;
      else                 elem = f;
   end
endmodule

// File: rtl/valu_slice.sv
module valu_slice #(
   parameter int unsigned VLEN = 128,
   parameter int unsigned XLEN = 32,
   parameter int unsigned W    = 8,
   parameter int unsigned VL_W = 5
) (
   input  logic [VLEN-1:0]    vs1,
   input  logic [VLEN-1:0]    vs2,
   input  logic [VLEN-1:0]    v0,
   input  logic [XLEN-1:0]    scalar,
   input  logic               scalar_sel,
   input  logic               mask_en,
   input  valu_pkg::valu_op_e op,
   input  logic [VL_W-1:0]    vl,
   output logic [VLEN-1:0]    vec
);
   localparam int unsigned N = VLEN / W;

   if (VLEN % W != 0) begin : g_bad_w
      $error("valu_slice: VLEN must be a multiple of W");
   end
   if (XLEN < W) begin : g_bad_x
      $error("valu_slice: XLEN must cover W");
   end

   logic [31:0] vl_ext;
   assign vl_ext = 32'(vl);

   for (genvar i = 0; i < N; i++) begin : g_el
      logic [W-1:0] opnd;
      logic         act;
      logic         inr;
      assign opnd = scalar_sel ? scalar[W-1:0] : vs1[i*W +: W];
      assign act  = !mask_en || v0[i*W];
      assign inr  = vl_ext > 32'(i);
      valu_lane #(.W(W)) u_lane (
         .opnd     (opnd),
         .base     (vs2[i*W +: W]),
         .op       (op),
         .active   (act),
         .in_range (inr),
         .elem     (vec[i*W +: W])
      );
   end
endmodule

// File: rtl/valu_top.sv
module valu_top #(
   parameter int unsigned VLEN = 128,
   parameter int unsigned XLEN = 32,
   parameter int unsigned VL_W = $clog2(VLEN / 8) + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [VLEN-1:0] vs1,
   input  logic [VLEN-1:0] vs2,
   input  logic [VLEN-1:0] v0,
   input  logic [XLEN-1:0] scalar,
   input  logic            scalar_sel,
   input  logic            mask_en,
   input  logic [2:0]      op,
   input  logic [1:0]      sew,
   input  logic [VL_W-1:0] vl,
   output logic [VLEN-1:0] result
);
   import valu_pkg::*;

   if (VLEN % 32 != 0 || VLEN < 32) begin : g_bad_vlen
      $error("valu_top: VLEN must be a nonzero multiple of 32");
   end
   if (XLEN < 32) begin : g_bad_xlen
      $error("valu_top: XLEN must be at least 32");
   end
   if ((1 << VL_W) <= VLEN / 8) begin : g_bad_vlw
      $error("valu_top: VL_W too narrow for the byte element count");
   end

   valu_op_e          op_e;
   logic [VLEN-1:0]   by_width [N_WIDTHS];
   logic [VLEN-1:0]   nxt;

   assign op_e = valu_op_e'(op);

   for (genvar k = 0; k < N_WIDTHS; k++) begin : g_w
      valu_slice #(
         .VLEN (VLEN),
         .XLEN (XLEN),
         .W    (8 << k),
         .VL_W (VL_W)
      ) u_slice (
         .vs1        (vs1),
         .vs2        (vs2),
         .v0         (v0),
         .scalar     (scalar),
         .scalar_sel (scalar_sel),
         .mask_en    (mask_en),
         .op         (op_e),
         .vl         (vl),
         .vec        (by_width[k])
      );
   end

   always_comb begin
      unique case (sew)
         SEW_8:   nxt = by_width[0];
         SEW_16:  nxt = by_width[1];
         SEW_32:  nxt = by_width[2];
         default: nxt = vs2;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) result <= '0;
      else        result <= nxt;
   end
endmodule

// File: rtl/valu_chk.sv
module valu_chk #(
   parameter int unsigned VLEN = 128,
   parameter int unsigned XLEN = 32,
   parameter int unsigned VL_W = 5
) (
   input logic            clk,
   input logic            rst_n,
   input logic [VLEN-1:0] vs1,
   input logic [VLEN-1:0] vs2,
   input logic [VLEN-1:0] v0,
   input logic [XLEN-1:0] scalar,
   input logic            scalar_sel,
   input logic            mask_en,
   input logic [2:0]      op,
   input logic [1:0]      sew,
   input logic [VL_W-1:0] vl,
   input logic [VLEN-1:0] result
);
   localparam logic [VL_W-1:0] VL_FULL = VL_W'(VLEN / 8);

   a_r1_reset_zero: assert property (@(posedge clk)
      $rose(rst_n) |-> (result == '0));

   a_r5_vl_zero_keeps_vs2: assert property (@(posedge clk) disable iff (!rst_n)
      (vl == '0) |=> (result == $past(vs2)));

   a_r7_masked_off_keeps_vs2: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_en && v0 == '0 && op != 3'd5) |=> (result == $past(vs2)));

   a_r8_masked_move_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_en && v0 == '0 && op == 3'd5 && sew != 2'd3 && vl == VL_FULL)
      |=> (result == '0));

   a_r4_and_bytes: assert property (@(posedge clk) disable iff (!rst_n)
      (op == 3'd2 && !mask_en && !scalar_sel && sew == 2'd0 && vl == VL_FULL)
      |=> (result == $past(vs1 & vs2)));

   a_r10_reserved_width: assert property (@(posedge clk) disable iff (!rst_n)
      (sew == 2'd3) |=> (result == $past(vs2)));
endmodule

bind valu_top valu_chk #(
   .VLEN (VLEN),
   .XLEN (XLEN),
   .VL_W (VL_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vs1        (vs1),
   .vs2        (vs2),
   .v0         (v0),
   .scalar     (scalar),
   .scalar_sel (scalar_sel),
   .mask_en    (mask_en),
   .op         (op),
   .sew        (sew),
   .vl         (vl),
   .result     (result)
);

// File: tb/tb_valu_top.sv
`timescale 1ns/1ps
module tb_valu_top;
   localparam int unsigned VLEN = 128;
   localparam int unsigned XLEN = 32;
   localparam int unsigned VL_W = $clog2(VLEN / 8) + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [VLEN-1:0] vs1 = '0, vs2 = '0, v0 = '0;
   logic [XLEN-1:0] scalar = '0;
   logic            scalar_sel = 1'b0, mask_en = 1'b0;
   logic [2:0]      op = 3'd0;
   logic [1:0]      sew = 2'd0;
   logic [VL_W-1:0] vl = '0;
   logic [VLEN-1:0] result;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   valu_top #(.VLEN(VLEN), .XLEN(XLEN), .VL_W(VL_W)) dut (
      .clk(clk), .rst_n(rst_n), .vs1(vs1), .vs2(vs2), .v0(v0),
      .scalar(scalar), .scalar_sel(scalar_sel), .mask_en(mask_en),
      .op(op), .sew(sew), .vl(vl), .result(result)
   );

   function automatic logic [VLEN-1:0] model(
      logic [VLEN-1:0] a1, logic [VLEN-1:0] a2, logic [VLEN-1:0] m,
      logic [XLEN-1:0] sc, logic ss, logic me, logic [2:0] o,
      logic [1:0] s, logic [VL_W-1:0] n_act);
      logic [VLEN-1:0] r;
      r = a2;
      if (s == 2'd3) return a2;
      begin
         int w, n;
         logic [63:0] msk;
         w   = 8 << s;
         n   = VLEN / w;
         msk = (64'd1 << w) - 64'd1;
         for (int i = 0; i < n; i++) begin
            logic [VLEN-1:0] t1, t2, tm;
            logic [63:0] x, y, e;
            logic act;
            t1 = a1 >> (i * w);
            t2 = a2 >> (i * w);
            tm = m  >> (i * w);
            y  = t2[63:0] & msk;
            x  = ss ? (64'(sc) & msk) : (t1[63:0] & msk);
            act = !me || tm[0];
            if (i >= int'(n_act))  e = y;
            else if (!act)         e = (o == 3'd5) ? 64'd0 : y;
            else begin
               case (o)
                  3'd0: e = y + x;
                  3'd1: e = y - x;
                  3'd2: e = y & x;
                  3'd3: e = y | x;
                  3'd4: e = y ^ x;
                  3'd5: e = x;
                  default: e = y;
               endcase
            end
            e &= msk;
            r = (r & ~({{(VLEN-64){1'b0}}, msk} << (i * w)))
              | ({{(VLEN-64){1'b0}}, e} << (i * w));
         end
      end
      return r;
   endfunction

   task automatic check(string tag, logic [VLEN-1:0] exp);
      checks++;
      if (result !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, result, exp);
      end
   endtask

   task automatic apply(string tag, logic [VLEN-1:0] a1, logic [VLEN-1:0] a2,
                        logic [VLEN-1:0] m, logic [XLEN-1:0] sc, logic ss,
                        logic me, logic [2:0] o, logic [1:0] s,
                        logic [VL_W-1:0] n);
      vs1 = a1; vs2 = a2; v0 = m; scalar = sc; scalar_sel = ss;
      mask_en = me; op = o; sew = s; vl = n;
      @(posedge clk);
      @(negedge clk);
      check(tag, model(a1, a2, m, sc, ss, me, o, s, n));
   endtask

   function automatic logic [VLEN-1:0] rnd();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   localparam logic [VL_W-1:0] FULL = VL_W'(VLEN / 8);
   localparam logic [VLEN-1:0] ONES = '1;

   initial begin
      @(negedge clk);
      check("R1 reset", '0);
      @(negedge clk);
      rst_n = 1'b1;
      check("R1 held after release", '0);

      // R3: carry must not spill across lanes, each width
      for (int s = 0; s < 3; s++) begin
         apply("R3 wrap add", {(VLEN/8){8'h01}}, ONES, '0, '0, 0, 0, 3'd0, 2'(s), FULL);
         apply("R3 wrap sub", ONES, '0, '0, '0, 0, 0, 3'd1, 2'(s), FULL);
      end
      check("R3 literal 32-bit borrow", {(VLEN/32){32'h0000_0001}});

      // R2: output holds until the next edge
      vs2 = ONES; op = 3'd0; vs1 = '0; sew = 2'd0; vl = FULL;
      #1;
      check("R2 holds before edge", {(VLEN/32){32'h0000_0001}});
      @(negedge clk);

      // R4: every operation code
      for (int o = 0; o < 8; o++)
         apply("R4 op code", rnd(), rnd(), '0, '0, 0, 0, 3'(o), 2'd1, FULL);

      // R5: tail lengths across widths
      for (int s = 0; s < 3; s++) begin
         apply("R5 tail vl=3", rnd(), rnd(), '0, '0, 0, 0, 3'd0, 2'(s), 5'd3);
         apply("R5 tail vl=0", rnd(), rnd(), '0, '0, 0, 0, 3'd4, 2'(s), 5'd0);
      end

      // R6: scalar form, upper scalar bits must be dropped
      for (int s = 0; s < 3; s++)
         apply("R6 scalar", rnd(), rnd(), '0, 32'hDEAD_BE7F, 1, 0, 3'd0, 2'(s), FULL);

      // R7, R8: same mask word under each width
      for (int s = 0; s < 3; s++) begin
         apply("R7 masked add", rnd(), rnd(), {(VLEN/32){32'h0100_0101}}, '0, 0, 1, 3'd1, 2'(s), FULL);
         apply("R8 masked move", rnd(), rnd(), {(VLEN/32){32'h0100_0101}}, '0, 0, 1, 3'd5, 2'(s), FULL);
         apply("R8 masked move scalar", rnd(), rnd(), rnd(), 32'h1234_5678, 1, 1, 3'd5, 2'(s), 5'd5);
      end
      apply("R8 all off", rnd(), rnd(), '0, '0, 0, 1, 3'd5, 2'd0, FULL);
      check("R8 literal zero", '0);

      // R9: mask disabled ignores v0
      apply("R9 unmasked move", rnd(), rnd(), '0, '0, 0, 0, 3'd5, 2'd0, FULL);
      apply("R9 unmasked xor", rnd(), rnd(), '0, '0, 0, 0, 3'd4, 2'd2, FULL);

      // R10: reserved width
      apply("R10 reserved", rnd(), rnd(), rnd(), '0, 0, 0, 3'd0, 2'd3, FULL);

      for (int k = 0; k < 400; k++)
         apply("R4 R5 R7 random", rnd(), rnd(), rnd(), $urandom, 1'($urandom),
               1'($urandom), 3'($urandom), 2'($urandom), VL_W'($urandom_range(0, 20)));

      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
      end
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
      end
      $finish;
   end
endmodule